// File: doc/BRIEF.md
# Reset cause capture controller

This block collects every request that can restart the chip and turns them into one system reset output. It also records which request started that reset. The requests are:

- a power-on indication
- an external reset pin
- brown-out detectors on three supplies (S, R and core)
- a clock-loss detector
- a hardware timeout
- a software cold-reset request
- a software warm-reset request

Software sees the block through one 32-bit register. The register holds the per-source enable bits and shows the recorded cause as a 3-bit code.

The block keeps only the first cause. Later requests that arrive while the reset is already held do not overwrite it. Capture is armed again only when two things have happened: every request has gone away, and the recorded code has been copied into a retention register. The copy takes one period of a slow clock, which is given to the block as a one-cycle `slow_tick` enable. Any request that arrives during that copy period is recorded as power-on, whatever caused it.

Two wake-from-shutdown flags are also kept in the register. An external pad-sleep-disable signal clears them.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After `rst_n` is released, `reg_rdata` reads 0x000001C0, `sys_rst` is 0 and `kept_cause` is 0.
- R2: The cause code sits in `reg_rdata[3:1]`. The codes are: 0 power-on, 1 pin, 2 brown-out on supply S, 4 brown-out on supply R or on the core supply, 5 clock loss, 6 hardware timeout or software cold reset, 7 warm reset. Code 3 is never reported.
- R3: When several gated requests start a reset in the same cycle, the lowest code among them is recorded.
- R4: Requests that arrive while `sys_rst` is already asserted do not change the recorded code.
- R5: Register bits 8, 7 and 6 enable the brown-outs of supply S, supply R and the core supply. When a bit is 0, that brown-out is ignored unless its override input (`bod_ovr[2]`, `[1]`, `[0]` respectively) is 1.
- R6: Register bit 5 enables clock loss. When it is 0, `clk_loss` is ignored.
- R7: `hw_timeout` always causes a reset, whatever the enable bits hold.
- R8: A write with bit 31 = 1 causes a reset recorded as code 6. A write with bit 31 = 0 causes none. Bit 31 always reads 0.
- R9: `sys_rst` rises in the cycle after a gated request is seen. It stays high while any gated request is active, and for two more `slow_tick` pulses after the last one drops.
- R10: One `slow_tick` after `sys_rst` falls, `kept_cause` takes the recorded code and capture is armed again.
- R11: A gated request that arrives after `sys_rst` falls but before that copy tick starts a reset recorded as code 0.
- R12: Read-only bits 15 and 14 are set by `wake_any` and `wake_io` and stay set. `pad_sleep_dis` clears both, and the clear wins over a set in the same cycle.
- R13: Writes leave every bit other than 31 and 8:5 unchanged, including the cause code and the wake flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| slow_tick | input | 1 | One-cycle enable once per slow-clock period |
| por_req | input | 1 | Power-on request |
| pin_req | input | 1 | External reset pin request |
| bod_s | input | 1 | Brown-out on supply S |
| bod_r | input | 1 | Brown-out on supply R |
| bod_core | input | 1 | Brown-out on the core supply |
| bod_ovr | input | 3 | Brown-out enable overrides: {S, R, core} |
| clk_loss | input | 1 | Clock-loss detect |
| hw_timeout | input | 1 | Hardware timeout, cannot be masked |
| warm_req | input | 1 | Warm-reset request |
| wake_any | input | 1 | Wake from shutdown occurred |
| wake_io | input | 1 | Wake from shutdown by an IO event |
| pad_sleep_dis | input | 1 | Clears both wake flags |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| sys_rst | output | 1 | System reset output, active high |
| kept_cause | output | 3 | Retained copy of the last recorded code |

## Verification
The assertions take these things for granted about the inputs:
- Requests are synchronous to `clk`.
- `slow_tick` is a single-cycle pulse.
- `pad_sleep_dis` is sampled as a level.

The stimulus respects this:
- Every request is driven away from the clock edge.
- Each request is held for at least one full cycle.
- `slow_tick` comes from a divide-by-four counter in the bench.

Because of that divider, the hold and copy windows are always a small, whole number of cycles. That lets the bench wait for `sys_rst` to fall and then place a new request inside the copy window on purpose.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int REG_W     = 32;

  // bit positions of the register fields
  localparam int B_COLD     = 31;
  localparam int B_WAKE_ANY = 15;
  localparam int B_WAKE_IO  = 14;
  localparam int B_EN_S     = 8;
  localparam int B_EN_R     = 7;
  localparam int B_EN_CORE  = 6;
  localparam int B_EN_CLK   = 5;
  localparam int B_CAUSE    = 1;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_POR   = 3'd0,
    CAUSE_PIN   = 3'd1,
    CAUSE_BOD_S = 3'd2,
    CAUSE_BOD_R = 3'd4,
    CAUSE_CLK   = 3'd5,
    CAUSE_COLD  = 3'd6,
    CAUSE_WARM  = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_HELD  = 2'd1,
    ST_COPY  = 2'd2
  } cap_st_e;

  typedef struct packed {
    logic bod_s;
    logic bod_r;
    logic bod_core;
    logic clk;
  } en_t;
endpackage

// File: rtl/rcc_src_gate.sv
module rcc_src_gate
  import rcc_pkg::*;
(
  input  logic                  por_req,
  input  logic                  pin_req,
  input  logic                  bod_s,
  input  logic                  bod_r,
  input  logic                  bod_core,
  input  logic [2:0]            bod_ovr,
  input  logic                  clk_loss,
  input  logic                  hw_timeout,
  input  logic                  cold_pulse,
  input  logic                  warm_req,
  input  en_t                   en,
  output logic                  any_req,
  output logic [CODE_W-1:0]     top_cause
);
  logic [NUM_CODES-1:0] req_by_code;

  // gate each source, grouped by the code it reports
  always_comb begin
    req_by_code              = '0;
    req_by_code[CAUSE_POR]   = por_req;
    req_by_code[CAUSE_PIN]   = pin_req;
    req_by_code[CAUSE_BOD_S] = bod_s & (en.bod_s | bod_ovr[2]);
    req_by_code[CAUSE_BOD_R] = (bod_r & (en.bod_r | bod_ovr[1]))
                             | (bod_core & (en.bod_core | bod_ovr[0]));
    req_by_code[CAUSE_CLK]   = clk_loss & en.clk;
    req_by_code[CAUSE_COLD]  = hw_timeout | cold_pulse;
    req_by_code[CAUSE_WARM]  = warm_req;
  end

  assign any_req = |req_by_code;

  // lowest code wins
  always_comb begin
    top_cause = CAUSE_POR;
    for (int c = NUM_CODES - 1; c >= 0; c--) begin
      if (req_by_code[c]) top_cause = CODE_W'(c);
    end
  end
endmodule

// File: rtl/rcc_capture.sv
module rcc_capture
  import rcc_pkg::*;
#(
  parameter int HOLD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              any_req,
  input  logic [CODE_W-1:0] top_cause,
  output logic              sys_rst,
  output logic [CODE_W-1:0] cause,
  output logic [CODE_W-1:0] kept
);
  localparam int CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

  cap_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] cause_q, cause_d;
  logic [CODE_W-1:0] kept_q, kept_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cause_d = cause_q;
    kept_d  = kept_q;
    case (st_q)
      ST_ARMED: begin
        if (any_req) begin
          st_d    = ST_HELD;
          cause_d = top_cause;
          cnt_d   = '0;
        end
      end
      ST_HELD: begin
        if (any_req) begin
          cnt_d = '0;
        end else if (slow_tick) begin
          if (cnt_q == CNT_LAST) begin
            st_d  = ST_COPY;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_COPY: begin
        if (any_req) begin
          st_d    = ST_HELD;
          cause_d = CAUSE_POR;
          cnt_d   = '0;
        end else if (slow_tick) begin
          kept_d = cause_q;
          st_d   = ST_ARMED;
        end
      end
      default: st_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_ARMED;
      cnt_q   <= '0;
      cause_q <= CAUSE_POR;
      kept_q  <= CAUSE_POR;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      cause_q <= cause_d;
      kept_q  <= kept_d;
    end
  end

  assign sys_rst = (st_q == ST_HELD);
  assign cause   = cause_q;
  assign kept    = kept_q;
endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CODE_W-1:0] cause,
  input  logic              wake_any,
  input  logic              wake_io,
  input  logic              pad_sleep_dis,
  output en_t               en,
  output logic              cold_pulse,
  output logic [REG_W-1:0]  rdata
);
  en_t  en_q, en_d;
  logic cold_q, cold_d;
  logic wk_any_q, wk_any_d;
  logic wk_io_q, wk_io_d;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[B_COLD-1:B_EN_S+1], wdata[B_EN_CLK-1:0]};

  always_comb begin
    en_d   = en_q;
    cold_d = we & wdata[B_COLD];
    if (we) begin
      en_d.bod_s    = wdata[B_EN_S];
      en_d.bod_r    = wdata[B_EN_R];
      en_d.bod_core = wdata[B_EN_CORE];
      en_d.clk      = wdata[B_EN_CLK];
    end
    wk_any_d = pad_sleep_dis ? 1'b0 : (wk_any_q | wake_any);
    wk_io_d  = pad_sleep_dis ? 1'b0 : (wk_io_q | wake_io);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '{bod_s: 1'b1, bod_r: 1'b1, bod_core: 1'b1, clk: 1'b0};
      cold_q   <= 1'b0;
      wk_any_q <= 1'b0;
      wk_io_q  <= 1'b0;
    end else begin
      en_q     <= en_d;
      cold_q   <= cold_d;
      wk_any_q <= wk_any_d;
      wk_io_q  <= wk_io_d;
    end
  end

  always_comb begin
    rdata                            = '0;
    rdata[B_WAKE_ANY]                = wk_any_q;
    rdata[B_WAKE_IO]                 = wk_io_q;
    rdata[B_EN_S]                    = en_q.bod_s;
    rdata[B_EN_R]                    = en_q.bod_r;
    rdata[B_EN_CORE]                 = en_q.bod_core;
    rdata[B_EN_CLK]                  = en_q.clk;
    rdata[B_CAUSE+CODE_W-1:B_CAUSE]  = cause;
  end

  assign en         = en_q;
  assign cold_pulse = cold_q;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int HOLD_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        por_req,
  input  logic        pin_req,
  input  logic        bod_s,
  input  logic        bod_r,
  input  logic        bod_core,
  input  logic [2:0]  bod_ovr,
  input  logic        clk_loss,
  input  logic        hw_timeout,
  input  logic        warm_req,
  input  logic        wake_any,
  input  logic        wake_io,
  input  logic        pad_sleep_dis,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sys_rst,
  output logic [2:0]  kept_cause
);
  en_t               en;
  logic              cold_pulse;
  logic              any_req;
  logic [CODE_W-1:0] top_cause;
  logic [CODE_W-1:0] cause;

  rcc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .cause(cause), .wake_any(wake_any), .wake_io(wake_io),
    .pad_sleep_dis(pad_sleep_dis), .en(en), .cold_pulse(cold_pulse),
    .rdata(reg_rdata)
  );

  rcc_src_gate u_gate (
    .por_req(por_req), .pin_req(pin_req), .bod_s(bod_s), .bod_r(bod_r),
    .bod_core(bod_core), .bod_ovr(bod_ovr), .clk_loss(clk_loss),
    .hw_timeout(hw_timeout), .cold_pulse(cold_pulse), .warm_req(warm_req),
    .en(en), .any_req(any_req), .top_cause(top_cause)
  );

  rcc_capture #(.HOLD_TICKS(HOLD_TICKS)) u_cap (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .any_req(any_req),
    .top_cause(top_cause), .sys_rst(sys_rst), .cause(cause),
    .kept(kept_cause)
  );
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sys_rst,
  input logic        any_req,
  input logic        hw_timeout,
  input logic        pad_sleep_dis,
  input logic [31:0] rdata,
  input logic [2:0]  kept_cause
);
  a_r9_rst_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> sys_rst);

  a_r9_fall_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> $past(!any_req));

  a_r7_timeout_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    hw_timeout |=> sys_rst);

  a_r4_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && $past(sys_rst)) |-> $stable(rdata[3:1]));

  a_r2_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[3:1] != 3'd3);

  a_r10_copy_outside_rst: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(kept_cause) |-> !sys_rst);

  a_r12_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pad_sleep_dis |=> (!rdata[15] && !rdata[14]));
endmodule

bind rst_cause_ctrl rcc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .any_req(any_req),
  .hw_timeout(hw_timeout), .pad_sleep_dis(pad_sleep_dis),
  .rdata(reg_rdata), .kept_cause(kept_cause)
);

// File: tb/rst_cause_ctrl_bench.sv
`timescale 1ns/1ps
module rst_cause_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slow_tick;
  logic        por_req, pin_req, bod_s, bod_r, bod_core;
  logic [2:0]  bod_ovr;
  logic        clk_loss, hw_timeout, warm_req;
  logic        wake_any, wake_io, pad_sleep_dis;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sys_rst;
  logic [2:0]  kept_cause;
  logic [1:0]  tdiv;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  rst_cause_ctrl u_rst_cause_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .por_req(por_req),
    .pin_req(pin_req), .bod_s(bod_s), .bod_r(bod_r), .bod_core(bod_core),
    .bod_ovr(bod_ovr), .clk_loss(clk_loss), .hw_timeout(hw_timeout),
    .warm_req(warm_req), .wake_any(wake_any), .wake_io(wake_io),
    .pad_sleep_dis(pad_sleep_dis), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_rst(sys_rst), .kept_cause(kept_cause)
  );

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdiv <= 2'd0;
    else        tdiv <= tdiv + 2'd1;
  end
  assign slow_tick = (tdiv == 2'd3);

  // {en S,R,core,clk}_{ovr S,R,core}_{por,pin,bs,br,bc,clk,to,warm}_{rst}_{code}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    19'b1110_000_01000000_1_001,
    19'b1110_000_00100001_1_010,
    19'b1110_000_00000100_0_010,
    19'b1111_000_00000101_1_101,
    19'b0000_000_00100000_0_101,
    19'b0000_100_00100000_1_010,
    19'b0000_001_00001000_1_100,
    19'b0000_000_00000010_1_110,
    19'b1110_000_00000001_1_111,
    19'b1110_000_11000001_1_000,
    19'b1110_000_00010000_1_100,
    19'b0000_000_00011100_0_100
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic set_src(input logic [7:0] s);
    {por_req, pin_req, bod_s, bod_r, bod_core, clk_loss, hw_timeout, warm_req} = s;
  endtask

  task automatic wait_low();
    for (int i = 0; i < 80; i++) begin
      if (!sys_rst) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0; bod_ovr = '0;
    set_src(8'h00); wake_any = 0; wake_io = 0; pad_sleep_dis = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(reg_rdata == 32'h1C0, "R1 rdata", reg_rdata, 32'h1C0);
    chk(sys_rst == 1'b0, "R1 sys_rst", sys_rst, 0);
    chk(kept_cause == 3'd0, "R1 kept", kept_cause, 0);

    // table: R2 R3 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VEC[v];
      wr({23'd0, e[18:15], 5'd0});
      @(negedge clk);
      bod_ovr = e[14:12];
      set_src(e[11:4]);
      cyc(2);
      chk(sys_rst == e[3], $sformatf("R5 R6 R7 vector %0d sys_rst", v), sys_rst, e[3]);
      set_src(8'h00); bod_ovr = '0;
      cyc(1);
      wait_low();
      cyc(12);
      chk(reg_rdata[3:1] == e[2:0], $sformatf("R2 R3 vector %0d code", v),
          reg_rdata[3:1], e[2:0]);
      if (e[3])
        chk(kept_cause == e[2:0], $sformatf("R10 vector %0d kept", v), kept_cause, e[2:0]);
    end

    // R8 cold reset by write
    wr(32'h8000_0000);
    cyc(1);
    chk(sys_rst == 1'b1, "R8 cold asserts", sys_rst, 1);
    wait_low(); cyc(12);
    chk(reg_rdata[3:1] == 3'd6, "R8 cold code", reg_rdata[3:1], 6);

    // R8 / R13 write with bit31 clear: no reset, read-only bits kept
    wr(32'h7FFF_FFFF);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (sys_rst) chk(1'b0, "R8 zero write reset", 1, 0);
    end
    chk(reg_rdata == 32'h0000_01EC, "R13 readonly after write", reg_rdata, 32'h1EC);

    // R4 + R9: root cause stays, hold after release
    @(negedge clk); pin_req = 1'b1;
    cyc(3); por_req = 1'b1;
    cyc(3); set_src(8'h00);
    cyc(2);
    chk(sys_rst == 1'b1, "R9 hold after release", sys_rst, 1);
    wait_low(); cyc(12);
    chk(reg_rdata[3:1] == 3'd1, "R4 root cause kept", reg_rdata[3:1], 1);

    // R11 request inside the copy window
    @(negedge clk); warm_req = 1'b1;
    cyc(2); warm_req = 1'b0;
    cyc(1);
    wait_low();
    pin_req = 1'b1;
    cyc(2); pin_req = 1'b0;
    chk(sys_rst == 1'b1, "R11 rst in window", sys_rst, 1);
    cyc(1); wait_low(); cyc(12);
    chk(reg_rdata[3:1] == 3'd0, "R11 window code", reg_rdata[3:1], 0);
    chk(kept_cause == 3'd0, "R11 kept", kept_cause, 0);

    // R12 wake flags
    @(negedge clk); wake_any = 1'b1; wake_io = 1'b1;
    @(negedge clk); wake_any = 1'b0; wake_io = 1'b0;
    cyc(2);
    chk(reg_rdata[15:14] == 2'b11, "R12 flags set", reg_rdata[15:14], 3);
    wr(32'h0000_0000);
    chk(reg_rdata[15:14] == 2'b11, "R13 flags survive write", reg_rdata[15:14], 3);
    @(negedge clk); pad_sleep_dis = 1'b1; wake_any = 1'b1;
    @(negedge clk); pad_sleep_dis = 1'b0; wake_any = 1'b0;
    chk(reg_rdata[15:14] == 2'b00, "R12 clear wins", reg_rdata[15:14], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule